// File: doc/BRIEF.md
# Iterative Multiply Unit with HI/LO Product Registers

This block is the integer multiply unit that sits next to a processor pipeline. It owns two architecturally visible 32-bit product registers. HI takes the upper half of a 64-bit product and LO takes the lower half. A small opcode input selects one of five operations: a signed multiply, an unsigned multiply, a read of HI, a read of LO, and a low-word multiply. The low-word multiply hands only the lower 32 bits of the signed product back to the pipeline.

The product is formed one bit per cycle by a shift-and-add datapath that keeps a running sum of partial products. The multiplier shifts right and only its least significant bit is examined. When that bit is 1, the multiplicand is added into the sum. The multiplicand shifts left on every step. Signed operands are first reduced to their magnitudes, and the 64-bit result is negated when the operand signs differ.

While a product is in progress the unit reports busy. Any operation presented during that time is stalled: it is not taken, and the pipeline holds it until busy drops. The control is a three-state machine:
- IDLE accepts operations.
- RUN performs the 32 iterations.
- DONE applies the sign correction and commits the result.

The transitions are:
- IDLE to RUN when a multiply is accepted.
- IDLE to IDLE for a read, a no-op or an unused code.
- RUN to RUN while iterations remain.
- RUN to DONE after the 32nd iteration.
- DONE to IDLE unconditionally.

Top module: `mdu_hilo`

## Requirements
- R1: After reset HI and LO read as zero, and busy, stall and rd_valid are low.
- R2: The unsigned multiply (op_code 2) writes HI with bits 63..32 and LO with bits 31..0 of the 64-bit unsigned product of src_a and src_b.
- R3: The signed multiply (op_code 1) writes HI and LO with the 64-bit two's complement product of src_a and src_b, including the most negative operand values.
- R4: The read of HI (op_code 3), accepted while not busy, drives rd_data with HI and raises rd_valid for one cycle on the cycle after acceptance.
- R5: The read of LO (op_code 4), accepted while not busy, drives rd_data with LO and raises rd_valid for one cycle on the cycle after acceptance.
- R6: The low-word multiply (op_code 5) raises rd_valid with bits 31..0 of the signed product on the cycle busy falls, and leaves HI and LO unchanged.
- R7: An accepted multiply (op_code 1, 2 or 5) holds busy high for exactly 33 cycles: 32 iterations and one commit cycle.
- R8: While busy, stall equals op_valid, and an operation presented then has no effect: it neither changes HI or LO nor produces rd_valid.
- R9: HI and LO change only in the commit cycle of a signed or unsigned multiply.
- R10: op_code 0 and the unused codes 6 and 7 do nothing: busy stays low, no rd_valid is produced, and HI and LO keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented |
| op_code | input | 3 | 0 none, 1 signed multiply, 2 unsigned multiply, 3 read HI, 4 read LO, 5 low-word multiply |
| src_a | input | 32 | Multiplicand operand |
| src_b | input | 32 | Multiplier operand |
| busy | output | 1 | A multiply is in progress |
| stall | output | 1 | The presented operation is not taken this cycle |
| rd_valid | output | 1 | rd_data carries a result this cycle |
| rd_data | output | 32 | Result returned to the destination |

## Verification
Several properties are checked on every cycle:
- stall appears only while busy.
- A result never appears while busy.
- Once accepted, a multiply raises busy.
- HI and LO hold their values in every cycle except a commit.
- A read of HI or LO returns the register value one cycle after acceptance.

Product values cannot be shown by those per-cycle checks and need the bench's scenarios:
- the correctness of the signed and unsigned products at the extremes;
- the exact 33-cycle busy length;
- the fact that the low-word multiply leaves HI and LO unchanged;
- the fact that operations held during a stall, and unused codes, leave no trace.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_MULS  = 3'd1,
        OP_MULU  = 3'd2,
        OP_MFHI  = 3'd3,
        OP_MFLO  = 3'd4,
        OP_MULLO = 3'd5
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mdu_state_e;

    typedef enum logic [1:0] {
        MODE_SIGNED   = 2'd0,
        MODE_UNSIGNED = 2'd1,
        MODE_LOWORD   = 2'd2
    } mdu_mode_e;
endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         is_signed,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         negate
);
    logic neg_a;
    logic neg_b;

    always_comb begin
        neg_a  = is_signed & opnd_a[W-1];
        neg_b  = is_signed & opnd_b[W-1];
        mag_a  = neg_a ? (~opnd_a + 1'b1) : opnd_a;
        mag_b  = neg_b ? (~opnd_b + 1'b1) : opnd_b;
        negate = neg_a ^ neg_b;
    end
endmodule

// File: rtl/mdu_shift_add_core.sv
module mdu_shift_add_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] sum_out,
    output logic           last_step
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [PW-1:0] sum_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            sum_q    <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            mcand_q  <= {{W{1'b0}}, mcand_in};
            mplier_q <= mplier_in;
            sum_q    <= '0;
            cnt_q    <= '0;
        end else if (step) begin
            if (mplier_q[0]) begin
                sum_q <= sum_q + mcand_q;
            end
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign sum_out   = sum_q;
    assign last_step = (cnt_q == LAST_CNT);
endmodule

// File: rtl/mdu_sign_fix.sv
module mdu_sign_fix #(
    parameter int PW = 64
) (
    input  logic [PW-1:0] raw,
    input  logic          negate,
    output logic [PW-1:0] fixed
);
    always_comb begin
        fixed = negate ? (~raw + 1'b1) : raw;
    end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         busy,
    output logic         stall,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    localparam int PW = 2 * W;

    mdu_state_e state_q;
    mdu_state_e state_d;
    mdu_mode_e  mode_q;
    logic       neg_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;

    logic accept;
    logic is_mul;
    logic signed_in;
    logic core_load;
    logic core_step;
    logic core_last;
    logic neg_in;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic [PW-1:0] raw_prod;
    logic [PW-1:0] fin_prod;

    always_comb begin
        is_mul    = (op_code == OP_MULS) || (op_code == OP_MULU) || (op_code == OP_MULLO);
        signed_in = (op_code == OP_MULS) || (op_code == OP_MULLO);
    end

    mdu_operand_prep #(.W(W)) u_prep (
        .opnd_a    (src_a),
        .opnd_b    (src_b),
        .is_signed (signed_in),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .negate    (neg_in)
    );

    mdu_shift_add_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (core_load),
        .step      (core_step),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .sum_out   (raw_prod),
        .last_step (core_last)
    );

    mdu_sign_fix #(.PW(PW)) u_fix (
        .raw    (raw_prod),
        .negate (neg_q),
        .fixed  (fin_prod)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        core_load = 1'b0;
        core_step = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = op_valid;
                if (op_valid && is_mul) begin
                    core_load = 1'b1;
                    state_d   = ST_RUN;
                end
            end
            ST_RUN: begin
                busy      = 1'b1;
                core_step = 1'b1;
                if (core_last) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                busy    = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        stall = op_valid && busy;
    end

    // Registered results and product registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            mode_q   <= MODE_SIGNED;
            neg_q    <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                if (op_code == OP_MFHI) begin
                    rd_data  <= hi_q;
                    rd_valid <= 1'b1;
                end else if (op_code == OP_MFLO) begin
                    rd_data  <= lo_q;
                    rd_valid <= 1'b1;
                end else if (is_mul) begin
                    neg_q <= neg_in;
                    if (op_code == OP_MULS) begin
                        mode_q <= MODE_SIGNED;
                    end else if (op_code == OP_MULU) begin
                        mode_q <= MODE_UNSIGNED;
                    end else begin
                        mode_q <= MODE_LOWORD;
                    end
                end
            end
            if (state_q == ST_DONE) begin
                if (mode_q == MODE_LOWORD) begin
                    rd_data  <= fin_prod[W-1:0];
                    rd_valid <= 1'b1;
                end else begin
                    hi_q <= fin_prod[PW-1:W];
                    lo_q <= fin_prod[W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [2:0]   op_code,
    input logic         busy,
    input logic         stall,
    input logic         rd_valid,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy); // R8

    AST_NO_RESULT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy); // R8

    AST_MUL_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && (op_code == 3'd1 || op_code == 3'd2 || op_code == 3'd5)) |=> busy); // R7

    AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || !$past(busy)) |-> ($stable(hi) && $stable(lo))); // R9

    AST_MFHI_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == 3'd3) |=> (rd_valid && rd_data == $past(hi))); // R4

    AST_MFLO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == 3'd4) |=> (rd_valid && rd_data == $past(lo))); // R5
endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .busy     (busy),
    .stall    (stall),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .hi       (hi_q),
    .lo       (lo_q)
);

// File: tb/mdu_hilo_test.sv
module mdu_hilo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy;
    logic        stall;
    logic        rd_valid;
    logic [31:0] rd_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit saw_stall;
    logic [31:0] hi_m = '0;
    logic [31:0] lo_m = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    mdu_hilo uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .src_a    (src_a),
        .src_b    (src_b),
        .busy     (busy),
        .stall    (stall),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected rd_valid", 64'(rd_data), 64'hDEAD_0000_0000_DEAD);
            end else begin
                check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            report();
        end
    end

    // Driver: presents an operation, holds it through stall, pushes expectations
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sp;
        logic [63:0] up;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        src_a    = a;
        src_b    = b;
        #1;
        while (stall) begin
            saw_stall = 1'b1;
            @(negedge clk);
            #1;
        end
        sp = 64'($signed(a)) * 64'($signed(b));
        up = {32'd0, a} * {32'd0, b};
        case (op)
            3'd1: begin hi_m = sp[63:32]; lo_m = sp[31:0]; end
            3'd2: begin hi_m = up[63:32]; lo_m = up[31:0]; end
            3'd3: begin exp_q.push_back(hi_m); tag_q.push_back("R4 read HI"); end
            3'd4: begin exp_q.push_back(lo_m); tag_q.push_back("R5 read LO"); end
            3'd5: begin exp_q.push_back(sp[31:0]); tag_q.push_back("R6 low-word multiply"); end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 3'd0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic mul_and_read(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        issue(op, a, b);
        wait_idle();
        issue(3'd3, 0, 0);
        issue(3'd4, 0, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 stall", 64'(stall), 64'd0);
        check("R1 rd_valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(3'd3, 0, 0);   // R1: HI reads zero
        issue(3'd4, 0, 0);   // R1: LO reads zero
        repeat (2) @(negedge clk);

        // R7 busy length, R2 unsigned extremes
        issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R7 busy cycles", 64'(n), 64'd33);
        repeat (2) @(negedge clk);
        issue(3'd3, 0, 0);
        issue(3'd4, 0, 0);
        repeat (2) @(negedge clk);
        mul_and_read(3'd2, 32'h1234_5678, 32'h9ABC_DEF0);   // R2
        mul_and_read(3'd2, 32'h0, 32'hDEAD_BEEF);           // R2 zero
        mul_and_read(3'd2, 32'h8000_0001, 32'h1);           // R2 identity

        // R3 signed
        mul_and_read(3'd1, 32'hFFFF_FFFD, 32'd7);
        mul_and_read(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        mul_and_read(3'd1, 32'h8000_0000, 32'h8000_0000);
        mul_and_read(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        mul_and_read(3'd1, 32'h8000_0000, 32'h0000_0001);

        // R6 low-word multiply: result on rd, HI/LO untouched (R9)
        issue(3'd5, 32'd12345, 32'hFFFF_E57B);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R7 busy cycles low-word", 64'(n), 64'd33);
        repeat (2) @(negedge clk);
        issue(3'd3, 0, 0);
        issue(3'd4, 0, 0);
        repeat (2) @(negedge clk);

        // R8 stall: read issued during a multiply waits for the product
        saw_stall = 1'b0;
        issue(3'd2, 32'h0001_0003, 32'h0002_0005);
        issue(3'd4, 0, 0);
        check("R8 stall observed", 64'(saw_stall), 64'd1);
        repeat (2) @(negedge clk);
        issue(3'd3, 0, 0);
        repeat (2) @(negedge clk);

        // R8 ignored while busy: a multiply held then withdrawn leaves no trace
        issue(3'd1, 32'd9, 32'd11);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd2; src_a = 32'hFFFF_0000; src_b = 32'h0F0F_0F0F;
        #1;
        check("R8 stall follows op_valid", 64'(stall), 64'd1);
        repeat (4) @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
        #1;
        check("R8 stall drops with op_valid", 64'(stall), 64'd0);
        wait_idle();
        issue(3'd3, 0, 0);
        issue(3'd4, 0, 0);
        repeat (2) @(negedge clk);

        // R10 nop and unused codes: no busy, no result, HI/LO kept
        issue(3'd0, 32'd5, 32'd5);
        check("R10 nop busy", 64'(busy), 64'd0);
        issue(3'd6, 32'd5, 32'd5);
        check("R10 code6 busy", 64'(busy), 64'd0);
        issue(3'd7, 32'd5, 32'd5);
        check("R10 code7 busy", 64'(busy), 64'd0);
        repeat (2) @(negedge clk);
        issue(3'd3, 0, 0);
        issue(3'd4, 0, 0);
        repeat (4) @(negedge clk);

        check("R4 R5 R6 all results seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        report();
    end
endmodule